// File: doc/BRIEF.md
# Receive ring buffer writer

This block takes the byte stream of received Ethernet frames, already framed by a MAC with start and end markers and a set of status flags, and stores each frame in a circular byte buffer held in on-chip RAM. Every frame begins at a 4-byte-aligned offset with a one-dword header. The header carries the frame's receive status and its byte count, and the payload follows directly behind it. A frame that runs past the top of the ring continues at offset 0. The host rebuilds the two pieces itself.

The host drives the block through a small register port. It selects the ring size, enables reception and issues a soft reset. It reports how far it has consumed by writing a read-pointer register that sits 16 bytes behind its real position. It polls an empty flag and a write-1-to-clear event register, and reads the ring contents one dword at a time through a read port with one cycle of latency. The ring length is `BASE_BYTES` shifted left by the size index. A chip instance sets `BASE_BYTES` to 8192, which gives 8, 16 or 32 KB. The default of 256 keeps the elaborated RAM small.

Top module: `rxring_writer`

## Requirements
- R1: The ring length is BASE_BYTES << idx, where idx is CFG (register 3) bits 1:0. idx 0, 1 and 2 give 1x, 2x and 4x, and idx 3 behaves as idx 2. All offsets wrap modulo this length.
- R2: Each committed frame has a header dword at its start offset. Bits 15:0 hold the status and bits 31:16 hold the number of bytes received, which includes the FCS bytes.
- R3: Status bits 15:1 are copied from rxFlags as sampled with the end byte, and input bit 0 is ignored. Status bit 0 (good) is 1 exactly when flag bits 1..5 (mask 0x003E: alignment, CRC, too long, runt, bad symbol) are all 0.
- R4: Payload byte k of a frame that starts at offset F lands at byte offset (F+4+k) mod length. Byte offset a maps to RAM word a>>2, bits 8*(a mod 4)+7 down to 8*(a mod 4).
- R5: The write pointer (register 4) moves from F to ((F+4+count+3) with bits 1:0 cleared) mod length. It is always dword aligned.
- R6: The header and the write-pointer update happen together on the clock edge one cycle after the edge that stores the end byte. During that intervening cycle the write pointer still holds its old value.
- R7: CMD (register 0) bit 0 is 1 exactly when the write pointer equals (RDPTR+16) mod length, where RDPTR is register 1.
- R8: ISR (register 2) bit 0 is set when a good frame commits. Writing 1 to an ISR bit clears it, and a new event in the same cycle wins over the clear.
- R9: If storing a byte would make count+8 exceed the free space (length minus (write pointer − host position) mod length), the frame is dropped. ISR bit 4 is set, no header is written and the write pointer does not move. A frame with count+8 equal to the free space is accepted.
- R10: If a byte arrives in the header-write cycle, the finished frame still commits, ISR bit 6 is set, and the frame that byte belongs to is discarded up to its end marker.
- R11: CMD bit 3 enables reception. A start marker seen while it is 0 is ignored together with the rest of that frame. Clearing it in mid-frame discards that frame with no event.
- R12: Writing 1 to CMD bit 4 clears the write pointer to 0, sets RDPTR to 0xFFF0 (host position 0), clears ISR and abandons any frame in progress. This bit reads back as 0.
- R13: A frame whose status has good = 0 is still stored and committed with its header, but it does not set ISR bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| rxValid | input | 1 | A received byte is present this cycle |
| rxData | input | 8 | Received byte |
| rxSof | input | 1 | Byte is the first of a frame |
| rxEof | input | 1 | Byte is the last of a frame |
| rxFlags | input | 16 | Frame status flags, valid with the end byte |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index: 0 CMD, 1 RDPTR, 2 ISR, 3 CFG, 4 WRPTR |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for regAddr (combinational) |
| memRdAddr | input | WAW | Ring RAM dword index for host reads |
| memRdData | output | 32 | Ring RAM dword, one cycle after memRdAddr |

## Verification
The bench drives every input just after a falling edge and samples one full cycle after the rising edge that should produce a result. A register write shows up at the first falling edge after its cycle. The header, the write pointer and the receive events show up at the second falling edge after the end byte is driven. The bench also checks, at the first falling edge, that the write pointer has not moved yet. A RAM dword is read at the falling edge after the cycle in which its address was presented. Each expected pointer, header and byte position is worked out in the bench from the alignment and wrap rules, for ring lengths of 256, 512 and 1024 bytes.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

  typedef struct packed {
    logic storeByte;
    logic firstByte;
    logic latchStat;
    logic writeHdr;
    logic setOvf;
    logic setFifo;
  } ringStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_DROP, ST_HDR} ringState_t;

  localparam logic [2:0] REG_CMD   = 3'd0;
  localparam logic [2:0] REG_RDPTR = 3'd1;
  localparam logic [2:0] REG_ISR   = 3'd2;
  localparam logic [2:0] REG_CFG   = 3'd3;
  localparam logic [2:0] REG_WRPTR = 3'd4;

  localparam logic [15:0] ISR_ROK  = 16'h0001;
  localparam logic [15:0] ISR_OVF  = 16'h0010;
  localparam logic [15:0] ISR_FIFO = 16'h0040;
  localparam logic [15:0] ISR_LIVE = ISR_ROK | ISR_OVF | ISR_FIFO;

  localparam int CMD_ENABLE_BIT = 3;
  localparam int CMD_RESET_BIT  = 4;

  localparam logic [15:0] STAT_ERR_MASK = 16'h003E;
  localparam logic [15:0] RDPTR_RESET   = 16'hFFF0;

endpackage

// File: rtl/rxring_regs.sv
module rxring_regs
  import rxring_pkg::*;
#(
  parameter int BASE_BYTES = 256,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWr,
  input  logic [2:0]    regAddr,
  input  logic [15:0]   regWrData,
  output logic [15:0]   regRdData,
  input  logic [AW-1:0] wrPtr,
  input  logic          setRok,
  input  logic          setOvf,
  input  logic          setFifo,
  output logic          rxEnable,
  output logic          softRst,
  output logic [AW-1:0] hostPos,
  output logic [AW:0]   lenBytes,
  output logic [AW-1:0] ptrMask
);

  logic [1:0]  sizeIdx;
  logic [1:0]  sizeEff;
  logic [15:0] rdPtr;
  logic [15:0] isr;
  logic [15:0] isrSet;
  logic [15:0] isrClr;
  logic        bufEmpty;
  logic        wrCmd, wrRdPtr, wrIsr, wrCfg;

  assign wrCmd   = regWr && (regAddr == REG_CMD);
  assign wrRdPtr = regWr && (regAddr == REG_RDPTR);
  assign wrIsr   = regWr && (regAddr == REG_ISR);
  assign wrCfg   = regWr && (regAddr == REG_CFG);
  assign softRst = wrCmd && regWrData[CMD_RESET_BIT];

  assign sizeEff  = (sizeIdx == 2'd3) ? 2'd2 : sizeIdx;
  assign lenBytes = (AW+1)'(BASE_BYTES) << sizeEff;
  assign ptrMask  = lenBytes[AW-1:0] - AW'(1);
  assign hostPos  = (rdPtr[AW-1:0] + AW'(16)) & ptrMask;
  assign bufEmpty = (wrPtr == hostPos);

  assign isrSet = (setRok ? ISR_ROK : 16'h0) | (setOvf ? ISR_OVF : 16'h0) |
                  (setFifo ? ISR_FIFO : 16'h0);
  assign isrClr = wrIsr ? (regWrData & ISR_LIVE) : 16'h0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxEnable <= 1'b0;
      rdPtr    <= RDPTR_RESET;
      isr      <= '0;
      sizeIdx  <= '0;
    end else begin
      if (wrCmd) rxEnable <= regWrData[CMD_ENABLE_BIT];
      if (wrCfg) sizeIdx <= regWrData[1:0];
      if (softRst) begin
        rdPtr <= RDPTR_RESET;
        isr   <= '0;
      end else begin
        if (wrRdPtr) rdPtr <= regWrData;
        isr <= (isr & ~isrClr) | isrSet;
      end
    end
  end

  always_comb begin
    case (regAddr)
      REG_CMD:   regRdData = {11'b0, 1'b0, rxEnable, 2'b00, bufEmpty};
      REG_RDPTR: regRdData = rdPtr;
      REG_ISR:   regRdData = isr;
      REG_CFG:   regRdData = {14'b0, sizeIdx};
      REG_WRPTR: regRdData = {{(16-AW){1'b0}}, wrPtr};
      default:   regRdData = 16'h0;
    endcase
  end

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (wrIsr && regWrData[0] && !setRok) |=> !isr[0]); // R8

  AST_SOFT_RESET_RDPTR: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (rdPtr == RDPTR_RESET && isr == 16'h0)); // R12

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (setOvf && !softRst) |=> isr[4]); // R9

endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
  import rxring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic        rxSof,
  input  logic        rxEof,
  input  logic        rxEnable,
  input  logic        softRst,
  input  logic        roomFirst,
  input  logic        roomNext,
  output ringStrobe_t strobe
);

  ringState_t state, nxt;

  always_comb begin
    nxt    = state;
    strobe = '0;
    if (softRst) begin
      nxt = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (rxValid && rxSof && rxEnable) begin
            if (roomFirst) begin
              strobe.storeByte = 1'b1;
              strobe.firstByte = 1'b1;
              if (rxEof) begin
                strobe.latchStat = 1'b1;
                nxt = ST_HDR;
              end else begin
                nxt = ST_DATA;
              end
            end else begin
              strobe.setOvf = 1'b1;
              nxt = rxEof ? ST_IDLE : ST_DROP;
            end
          end
        end
        ST_DATA: begin
          if (!rxEnable) begin
            nxt = (rxValid && rxEof) ? ST_IDLE : ST_DROP;
          end else if (rxValid) begin
            if (roomNext) begin
              strobe.storeByte = 1'b1;
              if (rxEof) begin
                strobe.latchStat = 1'b1;
                nxt = ST_HDR;
              end
            end else begin
              strobe.setOvf = 1'b1;
              nxt = rxEof ? ST_IDLE : ST_DROP;
            end
          end
        end
        ST_DROP: begin
          if (rxValid && rxEof) nxt = ST_IDLE;
        end
        ST_HDR: begin
          strobe.writeHdr = 1'b1;
          nxt = ST_IDLE;
          if (rxValid) begin
            strobe.setFifo = 1'b1;
            if (!rxEof) nxt = ST_DROP;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !rxEnable) |-> !strobe.storeByte); // R11

  AST_DROP_NO_HDR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setOvf |=> !strobe.writeHdr); // R9

  AST_HDR_AFTER_END: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeHdr |-> $past(strobe.latchStat)); // R6

endmodule

// File: rtl/rxring_dpath.sv
module rxring_dpath
  import rxring_pkg::*;
#(
  parameter int AW = 10,
  parameter int WAW = AW - 2,
  parameter int WORDS = 1 << WAW
) (
  input  logic           clk,
  input  logic           rstN,
  input  ringStrobe_t    strobe,
  input  logic           softRst,
  input  logic [7:0]     rxData,
  input  logic [15:0]    rxFlags,
  input  logic [AW-1:0]  hostPos,
  input  logic [AW:0]    lenBytes,
  input  logic [AW-1:0]  ptrMask,
  output logic           roomFirst,
  output logic           roomNext,
  output logic [AW-1:0]  wrPtr,
  output logic           hdrGood,
  input  logic [WAW-1:0] memRdAddr,
  output logic [31:0]    memRdData
);

  logic [31:0]    mem [WORDS];
  logic [15:0]    byteCnt;
  logic [15:0]    statQ;
  logic [AW-1:0]  usedBytes;
  logic [AW:0]    freeBytes;
  logic [AW-1:0]  byteIdx;
  logic [AW-1:0]  byteAddr;
  logic [AW-1:0]  nextPtr;
  logic [WAW-1:0] dataWord;
  logic [WAW-1:0] hdrWord;

  assign usedBytes = (wrPtr - hostPos) & ptrMask;
  assign freeBytes = lenBytes - {1'b0, usedBytes};
  assign roomFirst = freeBytes >= (AW+1)'(9);
  assign roomNext  = (17'(byteCnt) + 17'd9) <= 17'(freeBytes);

  assign byteIdx  = strobe.firstByte ? '0 : byteCnt[AW-1:0];
  assign byteAddr = (wrPtr + AW'(4) + byteIdx) & ptrMask;
  assign dataWord = byteAddr[AW-1:2];
  assign hdrWord  = wrPtr[AW-1:2];
  assign nextPtr  = (wrPtr + AW'(7) + byteCnt[AW-1:0]) & ptrMask & ~AW'(3);
  assign hdrGood  = statQ[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      byteCnt <= '0;
      statQ   <= '0;
    end else if (softRst) begin
      wrPtr   <= '0;
      byteCnt <= '0;
    end else begin
      if (strobe.storeByte)
        byteCnt <= strobe.firstByte ? 16'd1 : byteCnt + 16'd1;
      if (strobe.latchStat)
        statQ <= {rxFlags[15:1], ~|(rxFlags & STAT_ERR_MASK)};
      if (strobe.writeHdr)
        wrPtr <= nextPtr;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.writeHdr)
      mem[hdrWord] <= {byteCnt, statQ};
    else if (strobe.storeByte)
      mem[dataWord][{byteAddr[1:0], 3'b000} +: 8] <= rxData;
    memRdData <= mem[memRdAddr];
  end

  AST_WP_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    wrPtr[1:0] == 2'b00); // R5

  AST_WP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.writeHdr && !softRst) |=> $stable(wrPtr)); // R9

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.storeByte && strobe.writeHdr)); // R6

  AST_SOFT_RESET_WP: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> wrPtr == '0); // R12

endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
  import rxring_pkg::*;
#(
  parameter int BASE_BYTES = 256,
  localparam int MAX_BYTES = BASE_BYTES * 4,
  localparam int AW = $clog2(MAX_BYTES),
  localparam int WAW = AW - 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           rxValid,
  input  logic [7:0]     rxData,
  input  logic           rxSof,
  input  logic           rxEof,
  input  logic [15:0]    rxFlags,
  input  logic           regWr,
  input  logic [2:0]     regAddr,
  input  logic [15:0]    regWrData,
  output logic [15:0]    regRdData,
  input  logic [WAW-1:0] memRdAddr,
  output logic [31:0]    memRdData
);

  ringStrobe_t   strobe;
  logic          rxEnable, softRst, roomFirst, roomNext, hdrGood;
  logic [AW-1:0] wrPtr, hostPos, ptrMask;
  logic [AW:0]   lenBytes;

  rxring_regs #(.BASE_BYTES(BASE_BYTES), .AW(AW)) uRegs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .wrPtr(wrPtr),
    .setRok(strobe.writeHdr && hdrGood), .setOvf(strobe.setOvf),
    .setFifo(strobe.setFifo), .rxEnable(rxEnable), .softRst(softRst),
    .hostPos(hostPos), .lenBytes(lenBytes), .ptrMask(ptrMask)
  );

  rxring_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxSof(rxSof), .rxEof(rxEof),
    .rxEnable(rxEnable), .softRst(softRst), .roomFirst(roomFirst),
    .roomNext(roomNext), .strobe(strobe)
  );

  rxring_dpath #(.AW(AW), .WAW(WAW), .WORDS(1 << WAW)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .softRst(softRst),
    .rxData(rxData), .rxFlags(rxFlags), .hostPos(hostPos),
    .lenBytes(lenBytes), .ptrMask(ptrMask), .roomFirst(roomFirst),
    .roomNext(roomNext), .wrPtr(wrPtr), .hdrGood(hdrGood),
    .memRdAddr(memRdAddr), .memRdData(memRdData)
  );

endmodule

// File: tb/tb_rxring_writer.sv
`timescale 1ns/100ps
module tb_rxring_writer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxSof = 1'b0;
  logic        rxEof = 1'b0;
  logic [15:0] rxFlags = '0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [7:0]  memRdAddr = '0;
  logic [31:0] memRdData;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rxring_writer #(.BASE_BYTES(256)) dut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .rxSof(rxSof), .rxEof(rxEof), .rxFlags(rxFlags), .regWr(regWr),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .memRdAddr(memRdAddr), .memRdData(memRdData)
  );

  // {byte count, flags in, expected status}
  localparam logic [47:0] VEC [4] = '{
    48'h0040_0000_0001,
    48'h003D_2000_2001,
    48'h0046_0004_0004,
    48'h003F_4001_4001
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [15:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic memRead(input int byteOff, output logic [31:0] v);
    @(negedge clk);
    memRdAddr = 8'(byteOff >> 2);
    @(negedge clk);
    v = memRdData;
  endtask

  task automatic sendFrame(input int len, input logic [15:0] flags,
                           input logic [7:0] base, input bit gap);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rxValid = 1'b1; rxData = base + 8'(k);
      rxSof = (k == 0); rxEof = (k == len - 1); rxFlags = flags;
    end
    if (gap) begin
      @(negedge clk);
      rxValid = 1'b0; rxSof = 1'b0; rxEof = 1'b0;
    end
  endtask

  function automatic int nextPos(input int f, input int cnt, input int len);
    return ((f + 4 + cnt + 3) & ~3) % len;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    logic [15:0] r;
    logic [31:0] w;
    int wp;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state
    regRead(3'd0, r); chk("R7 empty after reset", 32'(r), 32'h0001);
    regRead(3'd1, r); chk("R12 rdptr reset", 32'(r), 32'hFFF0);
    regRead(3'd4, r); chk("R5 wrptr reset", 32'(r), 32'h0);
    regRead(3'd2, r); chk("R8 isr reset", 32'(r), 32'h0);

    // Frame while disabled
    sendFrame(64, 16'h0, 8'h00, 1'b1);
    @(negedge clk);
    regRead(3'd4, r); chk("R11 disabled frame ignored", 32'(r), 32'h0);
    regRead(3'd2, r); chk("R11 no event when disabled", 32'(r), 32'h0);

    // Vector walk, ring length 1024
    regWrite(3'd3, 16'h0002);
    regWrite(3'd0, 16'h0008);
    wp = 0;
    for (int i = 0; i < 4; i++) begin
      int len;
      int nxt;
      logic [15:0] fl, st;
      logic [7:0] base;
      len = int'(VEC[i][47:32]); fl = VEC[i][31:16]; st = VEC[i][15:0];
      base = 8'(8'h20 * i + 1);
      sendFrame(len, fl, base, 1'b1);
      regRead(3'd4, r); chk("R6 wrptr not yet moved", 32'(r), 32'(wp));
      @(negedge clk);
      nxt = nextPos(wp, len, 1024);
      regRead(3'd4, r); chk("R5 wrptr advance", 32'(r), 32'(nxt));
      memRead(wp, w); chk("R2 R3 R13 header", w, {16'(len), st});
      memRead(wp + 4 + len - 1, w);
      chk("R4 last payload byte", 32'(w >> (8 * ((wp + 3 + len) % 4))) & 32'hFF,
          32'(base + 8'(len - 1)));
      regRead(3'd2, r); chk("R8 R13 receive-ok event", 32'(r), {31'b0, st[0]});
      regWrite(3'd2, 16'h0001);
      regWrite(3'd1, 16'(nxt - 16));
      regRead(3'd0, r); chk("R7 empty after consume", 32'(r), 32'h0009);
      wp = nxt;
    end

    // Wrap at length 256
    regWrite(3'd0, 16'h0018);
    regWrite(3'd3, 16'h0000);
    sendFrame(200, 16'h0, 8'h00, 1'b1); @(negedge clk);
    regWrite(3'd1, 16'd188);
    sendFrame(100, 16'h0, 8'h40, 1'b1); @(negedge clk);
    regRead(3'd4, r); chk("R1 R5 wrap wrptr len256", 32'(r), 32'd52);
    memRead(0, w); chk("R4 wrapped byte at offset 0", w & 32'hFF, 32'h40 + 32'd48);
    memRead(204, w); chk("R2 header before wrap", w, {16'd100, 16'h0001});

    // Length 512
    regWrite(3'd0, 16'h0018);
    regWrite(3'd3, 16'h0001);
    sendFrame(200, 16'h0, 8'h00, 1'b1); @(negedge clk);
    regWrite(3'd1, 16'd188);
    sendFrame(400, 16'h0, 8'h00, 1'b1); @(negedge clk);
    regRead(3'd4, r); chk("R1 wrap wrptr len512", 32'(r), 32'd96);

    // Index 3 behaves as length 1024
    regWrite(3'd0, 16'h0018);
    regWrite(3'd3, 16'h0003);
    sendFrame(200, 16'h0, 8'h00, 1'b1); @(negedge clk);
    regWrite(3'd1, 16'd188);
    sendFrame(900, 16'h0, 8'h00, 1'b1); @(negedge clk);
    regRead(3'd4, r); chk("R1 index 3 as 1024", 32'(r), 32'd84);

    // Overflow boundary at length 256
    regWrite(3'd0, 16'h0018);
    regWrite(3'd3, 16'h0000);
    sendFrame(249, 16'h0, 8'h00, 1'b1); @(negedge clk);
    regRead(3'd4, r); chk("R9 dropped frame keeps wrptr", 32'(r), 32'h0);
    regRead(3'd2, r); chk("R9 overflow event", 32'(r), 32'h0010);
    sendFrame(248, 16'h0, 8'h00, 1'b1); @(negedge clk);
    regRead(3'd4, r); chk("R9 exact fit accepted", 32'(r), 32'd252);
    regRead(3'd0, r); chk("R7 not empty", 32'(r), 32'h0008);

    // Byte arriving in header cycle
    regWrite(3'd0, 16'h0018);
    sendFrame(64, 16'h0, 8'h00, 1'b0);
    sendFrame(64, 16'h0, 8'h80, 1'b1); @(negedge clk);
    regRead(3'd4, r); chk("R10 first frame committed only", 32'(r), 32'd68);
    regRead(3'd2, r); chk("R10 fifo event", 32'(r), 32'h0041);
    regWrite(3'd2, 16'h0001);
    regRead(3'd2, r); chk("R8 write-1-to-clear", 32'(r), 32'h0040);

    // Soft reset
    regWrite(3'd0, 16'h0018);
    regRead(3'd4, r); chk("R12 wrptr cleared", 32'(r), 32'h0);
    regRead(3'd1, r); chk("R12 rdptr reset value", 32'(r), 32'hFFF0);
    regRead(3'd2, r); chk("R12 isr cleared", 32'(r), 32'h0);
    regRead(3'd0, r); chk("R12 cmd readback", 32'(r), 32'h0009);

    // Disable in mid-frame
    fork
      sendFrame(64, 16'h0, 8'h00, 1'b1);
      begin repeat (10) @(negedge clk); regWr = 1'b1; regAddr = 3'd0; regWrData = 16'h0;
            @(negedge clk); regWr = 1'b0; end
    join
    @(negedge clk);
    regRead(3'd4, r); chk("R11 mid-frame disable drops", 32'(r), 32'h0);
    regRead(3'd2, r); chk("R11 mid-frame disable no event", 32'(r), 32'h0);

    summary();
  end

endmodule